// File: doc/BRIEF.md
# Supervisor Boot Bank Decoder

This block sorts every memory cycle of a 64K privileged CPU address space. A map-select input decides the path first. When it is high, the cycle goes to the user memory mapper, and only a user-map enable is raised. This happens even while the processor is still privileged. When map-select is low, the plain supervisor map applies. The space is cut into four 16K quarters, and the upper two address bits pick the quarter:

| Range | Contents |
|---|---|
| 0000–3FFF | Fixed boot ROM page |
| 4000–7FFF | Switchable ROM window |
| 8000–BFFF | Fixed RAM page |
| C000–FFFF | Switchable RAM window |

Two small bank registers hold the page shown in each switchable window. The ROM register is 3 bits wide and the RAM register is 4 bits wide. Both are loaded through an I/O write strobe. Each memory gets a page index. Index 0 is its fixed page. The banked pages follow as indices 1 upwards, so the index for a banked window is the register value plus one. The memory uses this index as its upper address bits.

A microcode extension store lives inside the fixed ROM quarter. A supervisor cycle that carries the extension-store qualifier and falls in that quarter raises the extension-store select in place of the ROM select.

Top module: `boot_bank_decoder`

## Requirements
- R1: While `mem_req` is low, `rom_cs`, `ram_cs`, `xstore_cs` and `user_map_en` are all low.
- R2: With `mem_req` high and `map_sel` high, only `user_map_en` is high, whatever the address and qualifier are.
- R3: A supervisor cycle (`mem_req`=1, `map_sel`=0, no extension-store hit) at addr[15:14]=00 raises `rom_cs` with `rom_page`=0.
- R4: A supervisor cycle at addr[15:14]=01 raises `rom_cs` with `rom_page` equal to the ROM bank register plus 1 (range 1..8).
- R5: A supervisor cycle at addr[15:14]=10 raises `ram_cs` with `ram_page`=0.
- R6: A supervisor cycle at addr[15:14]=11 raises `ram_cs` with `ram_page` equal to the RAM bank register plus 1 (range 1..16).
- R7: A supervisor cycle with `xs_qual`=1 at addr[15:14]=00 raises `xstore_cs` and keeps `rom_cs` low. Outside that quarter, `xs_qual` has no effect on any output.
- R8: When `bank_wr` is high at a rising clock edge, the write loads the register that `bank_wsel` picks, and the new page shows on the outputs from that edge on.
  - `bank_wsel`=0 loads `bank_wdata[2:0]` into the ROM bank register. Bit 3 is ignored.
  - `bank_wsel`=1 loads `bank_wdata[3:0]` into the RAM bank register.
  - The other register keeps its value.
- R9: Reset clears both bank registers, so the ROM window shows page 1 and the RAM window shows page 1.
- R10: During any cycle with `mem_req` high, exactly one of `rom_cs`, `ram_cs`, `xstore_cs`, `user_map_en` is high.
- R11: `rom_page` is 0 whenever `rom_cs` is low, and `ram_page` is 0 whenever `ram_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_req | input | 1 | Memory cycle strobe |
| map_sel | input | 1 | 1 sends the cycle to the user mapper |
| xs_qual | input | 1 | Marks an extension-store cycle |
| addr | input | 16 | CPU address |
| bank_wr | input | 1 | Bank register write strobe |
| bank_wsel | input | 1 | 0 writes the ROM bank register, 1 writes the RAM bank register |
| bank_wdata | input | 4 | Bank write data |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| xstore_cs | output | 1 | Extension store select |
| user_map_en | output | 1 | Hands the cycle to the user mapper |
| rom_page | output | 4 | ROM page index (upper address bits) |
| ram_page | output | 5 | RAM page index (upper address bits) |

## Verification
All selects and page indices are combinational from the cycle inputs. The bench therefore drives each cycle on a falling edge and samples a quarter period later, within the same cycle. A bank write is due one rising edge after its strobe. The bench model updates its copy of the registers only after checking the cycle that carried the write, so that cycle is still compared against the old page. Each following cycle is compared against the new page.

// File: rtl/bbd_pkg.sv
package bbd_pkg;

  // Quarter of the supervisor space, numbered by the two top address bits
  typedef enum logic [1:0] {
    RGN_ROM_FIX = 2'd0,
    RGN_ROM_WIN = 2'd1,
    RGN_RAM_FIX = 2'd2,
    RGN_RAM_WIN = 2'd3
  } region_e;

  typedef struct packed {
    logic rom;
    logic ram;
    logic xs;
    logic usr;
  } sel_t;

  function automatic region_e region_of(input logic [1:0] top2);
    return region_e'(top2);
  endfunction

  // Page index: fixed page is 0, banked pages follow from 1 (bank widths up to 7)
  function automatic logic [7:0] page_index(input logic banked, input logic [7:0] bank);
    return banked ? (bank + 8'd1) : 8'd0;
  endfunction

endpackage

// File: rtl/bbd_bank_regs.sv
module bbd_bank_regs #(
  parameter int ROM_W  = 3,
  parameter int RAM_W  = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [ROM_W-1:0]  rom_bank,
  output logic [RAM_W-1:0]  ram_bank
);

  logic rom_load, ram_load;
  assign rom_load = wr & ~wsel;
  assign ram_load = wr & wsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= '0;
      ram_bank <= '0;
    end else begin
      if (rom_load) rom_bank <= wdata[ROM_W-1:0];
      if (ram_load) ram_bank <= wdata[RAM_W-1:0];
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rom_bank == '0 && ram_bank == '0));

  // R8
  rom_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr) && !$past(wsel)) |-> (rom_bank == $past(wdata[ROM_W-1:0]) && $stable(ram_bank)));

  // R8
  ram_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr) && $past(wsel)) |-> (ram_bank == $past(wdata[RAM_W-1:0]) && $stable(rom_bank)));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr) |-> ($stable(rom_bank) && $stable(ram_bank)));

endmodule

// File: rtl/bbd_addr_decode.sv
module bbd_addr_decode
  import bbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              map_sel,
  input  logic              xs_qual,
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic              banked
);

  region_e rgn;
  logic    in_sup;
  logic    xs_hit;
  logic    rom_rgn;

  assign rgn     = region_of(addr[ADDR_W-1 -: 2]);
  assign in_sup  = mem_req & ~map_sel;
  assign rom_rgn = (rgn == RGN_ROM_FIX) || (rgn == RGN_ROM_WIN);
  assign xs_hit  = in_sup & xs_qual & (rgn == RGN_ROM_FIX);
  assign banked  = (rgn == RGN_ROM_WIN) || (rgn == RGN_RAM_WIN);

  always_comb begin
    sel     = '0;
    sel.usr = mem_req & map_sel;
    sel.xs  = xs_hit;
    sel.rom = in_sup & ~xs_hit & rom_rgn;
    sel.ram = in_sup & ~rom_rgn;
  end

  // R10
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $onehot(sel));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (sel == '0));

  // R7
  xs_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.xs |-> (addr[ADDR_W-1 -: 2] == 2'b00 && xs_qual && !map_sel && !sel.rom));

endmodule

// File: rtl/bbd_page_map.sv
module bbd_page_map
  import bbd_pkg::*;
#(
  parameter int BANK_W = 3,
  localparam int PAGE_W = BANK_W + 1
) (
  input  logic              cs,
  input  logic              banked,
  input  logic [BANK_W-1:0] bank,
  output logic [PAGE_W-1:0] page
);

  logic [7:0] idx;

  assign idx  = page_index(banked, 8'(bank));
  assign page = cs ? idx[PAGE_W-1:0] : '0;

endmodule

// File: rtl/boot_bank_decoder.sv
module boot_bank_decoder
  import bbd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ROM_BANK_W = 3,
  parameter int RAM_BANK_W = 4,
  parameter int DATA_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mem_req,
  input  logic                  map_sel,
  input  logic                  xs_qual,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  bank_wr,
  input  logic                  bank_wsel,
  input  logic [DATA_W-1:0]     bank_wdata,
  output logic                  rom_cs,
  output logic                  ram_cs,
  output logic                  xstore_cs,
  output logic                  user_map_en,
  output logic [ROM_BANK_W:0]   rom_page,
  output logic [RAM_BANK_W:0]   ram_page
);

  localparam int ROM_PAGE_W = ROM_BANK_W + 1;
  localparam int RAM_PAGE_W = RAM_BANK_W + 1;

  sel_t                  sel;
  logic                  banked;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;

  bbd_bank_regs #(.ROM_W(ROM_BANK_W), .RAM_W(RAM_BANK_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(bank_wr), .wsel(bank_wsel), .wdata(bank_wdata),
    .rom_bank(rom_bank), .ram_bank(ram_bank)
  );

  bbd_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .map_sel(map_sel),
    .xs_qual(xs_qual), .addr(addr), .sel(sel), .banked(banked)
  );

  // One page mapper per memory type
  for (genvar g = 0; g < 2; g++) begin : g_map
    if (g == 0) begin : g_rom
      bbd_page_map #(.BANK_W(ROM_BANK_W)) pm_i (
        .cs(sel.rom), .banked(banked), .bank(rom_bank), .page(rom_page)
      );
    end else begin : g_ram
      bbd_page_map #(.BANK_W(RAM_BANK_W)) pm_i (
        .cs(sel.ram), .banked(banked), .bank(ram_bank), .page(ram_page)
      );
    end
  end

  assign rom_cs      = sel.rom;
  assign ram_cs      = sel.ram;
  assign xstore_cs   = sel.xs;
  assign user_map_en = sel.usr;

  // R2
  user_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && map_sel) |-> (user_map_en && !rom_cs && !ram_cs && !xstore_cs));

  // R11
  page_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rom_cs -> rom_page == '0) && (!ram_cs -> ram_page == '0)));

  // R4
  rom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs && addr[ADDR_W-1 -: 2] == 2'b01) |-> (rom_page == ROM_PAGE_W'(rom_bank) + 1'b1));

  // R6
  ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs && addr[ADDR_W-1 -: 2] == 2'b11) |-> (ram_page == RAM_PAGE_W'(ram_bank) + 1'b1));

endmodule

// File: tb/boot_bank_decoder_tb.sv
module boot_bank_decoder_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req = 1'b0, map_sel = 1'b0, xs_qual = 1'b0;
  logic [15:0] addr = '0;
  logic        bank_wr = 1'b0, bank_wsel = 1'b0;
  logic [3:0]  bank_wdata = '0;
  logic        rom_cs, ram_cs, xstore_cs, user_map_en;
  logic [3:0]  rom_page;
  logic [4:0]  ram_page;

  int checks = 0;
  int fails  = 0;
  int m_rom  = 0;   // bench copy of ROM bank
  int m_ram  = 0;   // bench copy of RAM bank

  always #(CLK_P/2) clk = ~clk;

  boot_bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .map_sel(map_sel), .xs_qual(xs_qual),
    .addr(addr), .bank_wr(bank_wr), .bank_wsel(bank_wsel), .bank_wdata(bank_wdata),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .xstore_cs(xstore_cs), .user_map_en(user_map_en),
    .rom_page(rom_page), .ram_page(ram_page)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Select vector {rom,ram,xs,usr} expected from the requirements
  function automatic int exp_sel(input logic req, input logic ms, input logic q, input logic [1:0] top);
    if (!req) return 0;                        // R1
    if (ms) return 1;                          // R2
    if (top == 2'b00 && q) return 2;           // R7
    if (top[1] == 1'b0) return 8;              // R3 R4
    return 4;                                  // R5 R6
  endfunction

  function automatic int exp_rom_page(input int s, input logic [1:0] top);
    if (s != 8) return 0;                      // R11
    return (top == 2'b01) ? m_rom + 1 : 0;     // R3 R4
  endfunction

  function automatic int exp_ram_page(input int s, input logic [1:0] top);
    if (s != 4) return 0;                      // R11
    return (top == 2'b11) ? m_ram + 1 : 0;     // R5 R6
  endfunction

  task automatic cycle(input logic req, input logic ms, input logic q, input logic [15:0] a,
                       input logic wr, input logic ws, input logic [3:0] wd, input string tag);
    int s;
    @(negedge clk);
    mem_req = req; map_sel = ms; xs_qual = q; addr = a;
    bank_wr = wr; bank_wsel = ws; bank_wdata = wd;
    #(CLK_P/4);
    s = exp_sel(req, ms, q, a[15:14]);
    check({tag, " R10 selects"}, int'({rom_cs, ram_cs, xstore_cs, user_map_en}), s);
    check({tag, " rom_page"}, int'(rom_page), exp_rom_page(s, a[15:14]));
    check({tag, " ram_page"}, int'(ram_page), exp_ram_page(s, a[15:14]));
    if (wr) begin                              // R8: visible after this edge
      if (!ws) m_rom = int'(wd[2:0]);
      else     m_ram = int'(wd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state: both windows at page 1
    cycle(1, 0, 0, 16'h4123, 0, 0, 0, "R9 rom");
    cycle(1, 0, 0, 16'hC456, 0, 0, 0, "R9 ram");
    cycle(0, 0, 0, 16'h0000, 0, 0, 0, "R1 idle");
    cycle(1, 0, 0, 16'h0010, 0, 0, 0, "R3 fixed rom");
    cycle(1, 0, 0, 16'h8010, 0, 0, 0, "R5 fixed ram");
    // R8 ROM write ignores bit 3: 4'hF gives bank 7 -> page 8
    cycle(0, 0, 0, 16'h0000, 1, 0, 4'hF, "R8 wr rom");
    cycle(1, 0, 0, 16'h7FFF, 0, 0, 0, "R4 top rom");
    cycle(1, 0, 0, 16'hC000, 0, 0, 0, "R8 ram kept");
    cycle(0, 0, 0, 16'h0000, 1, 1, 4'hF, "R8 wr ram");
    cycle(1, 0, 0, 16'hFFFF, 0, 0, 0, "R6 top ram");
    cycle(1, 0, 0, 16'h4000, 0, 0, 0, "R8 rom kept");
    // R7 extension store
    cycle(1, 0, 1, 16'h3FFF, 0, 0, 0, "R7 xs hit");
    cycle(1, 0, 1, 16'h4000, 0, 0, 0, "R7 xs ignored rom win");
    cycle(1, 0, 1, 16'hC000, 0, 0, 0, "R7 xs ignored ram win");
    // R2 user map wins over everything
    cycle(1, 1, 1, 16'h0000, 0, 0, 0, "R2 user");
    cycle(1, 1, 0, 16'hC000, 0, 0, 0, "R2 user ram");
    cycle(0, 1, 1, 16'h0000, 0, 0, 0, "R1 idle user");

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom();
      cycle(r[0] | r[1], r[2] & r[3], r[4], r[31:16], r[5] & r[6], r[7], r[11:8], "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule